// File: doc/BRIEF.md
# Two-Way Lockable Cache Tag Controller

This block holds the tags and the replacement state of a two-way set-associative instruction cache placed between a processor and a system bus. Each set keeps one tag per way, a valid and a lock flag per line, and one least-recently-used bit. A read is sorted into one of five outcomes. It can hit. It can miss and allocate a line. It can miss and be sent to the bus as a single non-sequential fetch with no allocation. It can pass straight through. It can be a direct access to the tag or data arrays. The result is registered and appears one cycle after the request.

Four configuration inputs select the mode: enable, global lock, line-lock mode and test mode. A flush pulse starts a sweep that clears one set per clock. The same sweep starts by itself when reset is released, and caching is suspended while it runs. In line-lock mode, software places code into the arrays by hand, and every tag it writes becomes valid and locked. Test mode gives raw access to both arrays for diagnostics. The data array here is a plain internal store, and the bus side of a line fill is not modelled.

Top module: `ctc_tag_ctrl`

## Requirements
- R1: While reset is low, `rsp_valid` is 0 and `flush_busy` is 1. When reset is released, a sweep starts by itself, and all lookups miss once it ends.
- R2: `flush_busy` stays high for exactly 128 consecutive sampled cycles after reset release or after a `flush_req` pulse, then falls by itself.
- R3: A request accepted while `flush_busy` is 1 gets the pass-through outcome. After a sweep, every valid bit, lock bit and LRU bit is 0, while the stored tag values are kept.
- R4: With enable low, no test mode and no lock mode, a request passes through. A write with enable high also passes through.
- R5: Address bits [10:4] pick the set, bits [3:2] pick the word in a 16-byte line, and bits [31:11] form the tag.
- R6: A read that matches a valid tag hits. `rsp_way` gives the way and `rsp_rdata` returns that way's data word. The set's LRU bit then points to the other way.
- R7: A miss in a set with no locked line allocates the way named by the LRU bit (0 after a sweep), installs the tag as valid, and points the LRU bit at the other way.
- R8: A miss in a set with exactly one locked line allocates the unlocked way, whatever the LRU bit says.
- R9: A miss in a set with both lines locked gives the non-sequential-fetch outcome and changes no tag or flag.
- R10: While global lock is high, a miss gives the non-sequential-fetch outcome and hits still hit. Per-line lock bits do not change, and allocation resumes once global lock is low.
- R11: Lock mode, when test mode is low, turns every request into an array access. A tag write stores `cpu_wdata[31:11]` and sets that line's valid and lock bits.
- R12: Test mode gives array access, with priority over lock mode. A tag write changes only the tag. A tag read returns the tag in [31:11], the LRU bit in [2] (way 0 only, 0 for way 1), the lock bit in [1] and the valid bit in [0]. Array writes return 0.
- R13: A `flush_req` during a sweep restarts it, so `flush_busy` stays high for 128 cycles counted from the new pulse.
- R14: `rsp_valid` follows the request by one cycle. Exactly one of `rsp_hit`, `rsp_fill`, `rsp_nseq`, `rsp_bypass`, `rsp_ram` is 1 when `rsp_valid` is 1, and none is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Caching enabled |
| cfg_global_lock | input | 1 | Freeze all replacement |
| cfg_lock_mode | input | 1 | Line-lock mode (direct array access, tag writes lock) |
| cfg_test_mode | input | 1 | Test mode (direct array access, flags read-only) |
| flush_req | input | 1 | Pulse that starts or restarts a sweep |
| flush_busy | output | 1 | Sweep in progress |
| cpu_req | input | 1 | Request strobe, one cycle per request |
| cpu_we | input | 1 | Write |
| cpu_tag_sel | input | 1 | Array access target: 1 tag array, 0 data array |
| cpu_way | input | 1 | Array access way |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fill | output | 1 | Miss, line allocated (fill requested) |
| rsp_nseq | output | 1 | Miss, single non-sequential fetch, no allocation |
| rsp_bypass | output | 1 | Passed through to the bus |
| rsp_ram | output | 1 | Direct array access done |
| rsp_way | output | 1 | Way hit or allocated |
| rsp_rdata | output | 32 | Data on hit or array read, else 0 |

## Verification
The hardest state to reach from the ports is a set with a locked line whose LRU bit points at that locked way. A set with both ways locked while the stored tags differ from the address under test is equally hard. The stimulus reaches both by writing tags directly in line-lock mode and then reading neighbouring tags of the same set. Test-mode tag reads then bring the lock, valid and LRU flags back out, so they can be checked after global lock has been toggled and after sweeps. A second flush pulse, sent in the middle of a running sweep, shows that the sweep restarts.

// File: rtl/ctc_pkg.sv
// Shared types and constants for the cache tag controller.
// Assumes a fixed two-way organisation; set count and line size are parameters of the top.
package ctc_pkg;

    localparam int WAYS = 2;

    // Request class chosen from mode inputs, highest priority first: sweep, test, lock, lookup.
    typedef enum logic [1:0] {
        ACC_BYPASS = 2'd0,
        ACC_TEST   = 2'd1,
        ACC_LOCK   = 2'd2,
        ACC_LOOKUP = 2'd3
    } acc_t;

endpackage

// File: rtl/ctc_flush_seq.sv
// Sweep sequencer: walks every set index once, one per clock, while busy is high.
// Starts out of reset and on every start pulse; a pulse while busy restarts from set 0.
module ctc_flush_seq #(
    parameter int SETS  = 128,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] clr_idx
);

    // Sweep counter and busy flag; busy drops after the last set is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b1;
            clr_idx <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            clr_idx <= '0;
        end else if (busy) begin
            if (clr_idx == IDX_W'(SETS - 1)) busy <= 1'b0;
            clr_idx <= clr_idx + 1'b1;
        end
    end

endmodule

// File: rtl/ctc_victim_sel.sv
// Replacement choice for one set: never a locked way, nothing when both are locked
// or when global lock is set; otherwise the LRU way.
module ctc_victim_sel (
    input  logic [1:0] lock_bits,
    input  logic       lru_bit,
    input  logic       global_lock,
    output logic       can_fill,
    output logic       victim
);

    // Pick the way to allocate and whether allocation is allowed.
    always_comb begin
        can_fill = 1'b1;
        victim   = lru_bit;
        if (global_lock || (&lock_bits)) begin
            can_fill = 1'b0;
        end else if (lock_bits[0]) begin
            victim = 1'b1;
        end else if (lock_bits[1]) begin
            victim = 1'b0;
        end
    end

endmodule

// File: rtl/ctc_tag_ctrl.sv
// Two-way lockable cache tag controller (top).
// Classifies each request (hit, allocate, single fetch, pass-through, array access),
// keeps per-line valid/lock flags and a per-set LRU bit, and runs the sweep.
// Assumes DATA_W == ADDR_W so a tag read can place the tag at the top of the word,
// and one request at most per cycle; responses are registered one cycle later.
module ctc_tag_ctrl
    import ctc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 16,
    localparam int OFS_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int WPL   = LINE_BYTES / 4,
    localparam int WRD_W = $clog2(WPL),
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_global_lock,
    input  logic              cfg_lock_mode,
    input  logic              cfg_test_mode,
    input  logic              flush_req,
    output logic              flush_busy,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_tag_sel,
    input  logic              cpu_way,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fill,
    output logic              rsp_nseq,
    output logic              rsp_bypass,
    output logic              rsp_ram,
    output logic              rsp_way,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [TAG_W-1:0]  tag_mem  [WAYS][SETS];
    logic [DATA_W-1:0] data_mem [WAYS][SETS*WPL];
    logic [SETS-1:0]   vld      [WAYS];
    logic [SETS-1:0]   lck      [WAYS];
    logic [SETS-1:0]   lru;

    logic [IDX_W-1:0]  idx;
    logic [WRD_W-1:0]  wrd;
    logic [TAG_W-1:0]  atag;
    logic [IDX_W-1:0]  clr_idx;
    logic [WAYS-1:0]   way_hit;
    logic              hit_any;
    logic              hit_way;
    logic              can_fill;
    logic              victim;
    logic              ram_acc;
    logic              tag_wr;
    logic              data_wr;
    logic              fill_now;
    logic              lookup;
    logic [DATA_W-1:0] tag_word;
    acc_t              acc;
    logic              unused_ok;

    assign idx       = cpu_addr[OFS_W +: IDX_W];
    assign wrd       = cpu_addr[2 +: WRD_W];
    assign atag      = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_ok = &{1'b0, cpu_addr[1:0]};

    ctc_flush_seq #(.SETS(SETS)) u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (flush_req),
        .busy    (flush_busy),
        .clr_idx (clr_idx)
    );

    // Per-way tag comparison against the requested address.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = vld[w][idx] && (tag_mem[w][idx] == atag);
    end
    assign hit_any = |way_hit;
    assign hit_way = way_hit[1];

    ctc_victim_sel u_vict (
        .lock_bits   ({lck[1][idx], lck[0][idx]}),
        .lru_bit     (lru[idx]),
        .global_lock (cfg_global_lock),
        .can_fill    (can_fill),
        .victim      (victim)
    );

    // Request class by mode priority: sweep, test, lock, disabled or write, lookup.
    always_comb begin
        if (flush_busy)                  acc = ACC_BYPASS;
        else if (cfg_test_mode)          acc = ACC_TEST;
        else if (cfg_lock_mode)          acc = ACC_LOCK;
        else if (!cfg_enable || cpu_we)  acc = ACC_BYPASS;
        else                             acc = ACC_LOOKUP;
    end

    assign ram_acc  = cpu_req && (acc == ACC_TEST || acc == ACC_LOCK);
    assign tag_wr   = ram_acc && cpu_we && cpu_tag_sel;
    assign data_wr  = ram_acc && cpu_we && !cpu_tag_sel;
    assign lookup   = cpu_req && (acc == ACC_LOOKUP);
    assign fill_now = lookup && !hit_any && can_fill;

    // Tag-array read word: tag at the top, then LRU (way 0 only), lock and valid.
    always_comb begin
        tag_word                    = '0;
        tag_word[ADDR_W-1 -: TAG_W] = tag_mem[cpu_way][idx];
        tag_word[2]                 = lru[idx] & ~cpu_way;
        tag_word[1]                 = lck[cpu_way][idx];
        tag_word[0]                 = vld[cpu_way][idx];
    end

    // Valid, lock and LRU flags: reset, sweep clear, lock-mode tag writes, lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                vld[w] <= '0;
                lck[w] <= '0;
            end
            lru <= '0;
        end else if (flush_busy) begin
            for (int w = 0; w < WAYS; w++) begin
                vld[w][clr_idx] <= 1'b0;
                lck[w][clr_idx] <= 1'b0;
            end
            lru[clr_idx] <= 1'b0;
        end else if (tag_wr && acc == ACC_LOCK) begin
            vld[cpu_way][idx] <= 1'b1;
            lck[cpu_way][idx] <= 1'b1;
        end else if (lookup && hit_any) begin
            lru[idx] <= ~hit_way;
        end else if (fill_now) begin
            vld[victim][idx] <= 1'b1;
            lru[idx]         <= ~victim;
        end
    end

    // Tag array: direct writes in test/lock mode and tag install on allocation.
    always_ff @(posedge clk) begin
        if (tag_wr) begin
            tag_mem[cpu_way][idx] <= cpu_wdata[DATA_W-1 -: TAG_W];
        end else if (fill_now) begin
            tag_mem[victim][idx] <= atag;
        end
    end

    // Data array: direct writes in test/lock mode only.
    always_ff @(posedge clk) begin
        if (data_wr) data_mem[cpu_way][{idx, wrd}] <= cpu_wdata;
    end

    // Registered response: one outcome flag, way and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fill   <= 1'b0;
            rsp_nseq   <= 1'b0;
            rsp_bypass <= 1'b0;
            rsp_ram    <= 1'b0;
            rsp_way    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid  <= cpu_req;
            rsp_hit    <= lookup && hit_any;
            rsp_fill   <= fill_now;
            rsp_nseq   <= lookup && !hit_any && !can_fill;
            rsp_bypass <= cpu_req && (acc == ACC_BYPASS);
            rsp_ram    <= ram_acc;
            rsp_way    <= (lookup && hit_any) ? hit_way : (fill_now ? victim : 1'b0);
            if (ram_acc && !cpu_we)
                rsp_rdata <= cpu_tag_sel ? tag_word : data_mem[cpu_way][{idx, wrd}];
            else if (lookup && hit_any)
                rsp_rdata <= data_mem[hit_way][{idx, wrd}];
            else
                rsp_rdata <= '0;
        end
    end

endmodule

// File: rtl/ctc_tag_ctrl_chk.sv
// Property checker for the cache tag controller, attached by bind.
// Watches ports only; a local counter measures sweep length.
module ctc_tag_ctrl_chk #(
    parameter int SETS = 128,
    localparam int CW = $clog2(SETS) + 2
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_global_lock,
    input logic cfg_lock_mode,
    input logic cfg_test_mode,
    input logic flush_req,
    input logic flush_busy,
    input logic cpu_req,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_fill,
    input logic rsp_nseq,
    input logic rsp_bypass,
    input logic rsp_ram
);

    logic [CW-1:0] busy_cnt;

    // Count cycles of busy since the last reset or flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_req) busy_cnt <= '0;
        else if (flush_busy)     busy_cnt <= busy_cnt + 1'b1;
    end

    // R2 / R13: the sweep ends exactly SETS cycles after it started.
    assert_flush_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> busy_cnt == CW'(SETS));

    // R3: requests during a sweep pass through.
    assert_flush_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_req && flush_busy) |-> rsp_bypass);

    // R4: disabled cache passes reads through.
    assert_disabled_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_req && !flush_busy && !cfg_test_mode && !cfg_lock_mode && !cfg_enable)
        |-> rsp_bypass);

    // R10: no allocation under global lock.
    assert_glock_nofill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_req && cfg_global_lock) |-> !rsp_fill);

    // R11: lock mode never does a lookup.
    assert_lockmode_ram_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cpu_req && !flush_busy && cfg_lock_mode) |-> rsp_ram);

    // R14: response one cycle after the request.
    assert_rsp_timing_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(cpu_req));

    // R14: exactly one outcome with a response, none without.
    assert_one_outcome_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rsp_hit, rsp_fill, rsp_nseq, rsp_bypass, rsp_ram}) == (rsp_valid ? 1 : 0));

endmodule

bind ctc_tag_ctrl ctc_tag_ctrl_chk #(.SETS(SETS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_enable      (cfg_enable),
    .cfg_global_lock (cfg_global_lock),
    .cfg_lock_mode   (cfg_lock_mode),
    .cfg_test_mode   (cfg_test_mode),
    .flush_req       (flush_req),
    .flush_busy      (flush_busy),
    .cpu_req         (cpu_req),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_fill        (rsp_fill),
    .rsp_nseq        (rsp_nseq),
    .rsp_bypass      (rsp_bypass),
    .rsp_ram         (rsp_ram)
);

// File: tb/test_ctc_tag_ctrl.sv
// Bench for the cache tag controller: a vector table walked by one loop,
// then directed tests for reset, sweep length, sweep clearing and restart.
module test_ctc_tag_ctrl;

    localparam logic [2:0] K_HIT  = 3'd0;
    localparam logic [2:0] K_FILL = 3'd1;
    localparam logic [2:0] K_NSEQ = 3'd2;
    localparam logic [2:0] K_BYP  = 3'd3;
    localparam logic [2:0] K_RAM  = 3'd4;

    // mode = {enable, global_lock, lock_mode, test_mode}
    localparam logic [3:0] M_DIS  = 4'b0000;
    localparam logic [3:0] M_TS   = 4'b0001;
    localparam logic [3:0] M_LK   = 4'b0010;
    localparam logic [3:0] M_EN   = 4'b1000;
    localparam logic [3:0] M_ENLK = 4'b1010;
    localparam logic [3:0] M_ENGL = 4'b1100;

    typedef struct packed {
        logic [3:0]  mode;
        logic        we;
        logic        tsel;
        logic        way;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [2:0]  kind;
        logic        eway;
        logic [31:0] erd;
        logic        ck;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{M_TS,   1'b1, 1'b0, 1'b0, 32'h1230, 32'h1111_0000, K_RAM,  1'b0, 32'h0,         1'b1, "R12 "}, // data write way0
        '{M_TS,   1'b1, 1'b0, 1'b1, 32'h1230, 32'h2222_0000, K_RAM,  1'b0, 32'h0,         1'b1, "R12 "}, // data write way1
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h1230, 32'h0,         K_FILL, 1'b0, 32'h0,         1'b0, "R7  "}, // LRU 0 -> way0
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h1230, 32'h0,         K_HIT,  1'b0, 32'h1111_0000, 1'b1, "R6  "},
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h1A30, 32'h0,         K_FILL, 1'b1, 32'h0,         1'b0, "R7  "}, // same set, LRU -> way1
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h1A30, 32'h0,         K_HIT,  1'b1, 32'h2222_0000, 1'b1, "R6  "},
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h2230, 32'h0,         K_FILL, 1'b0, 32'h0,         1'b0, "R7  "}, // evicts tag 2
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h1230, 32'h0,         K_FILL, 1'b1, 32'h0,         1'b0, "R5  "}, // tag 2 gone, same index
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h2230, 32'h0,         K_HIT,  1'b0, 32'h1111_0000, 1'b1, "R6  "}, // LRU -> 1
        '{M_TS,   1'b0, 1'b1, 1'b0, 32'h1230, 32'h0,         K_RAM,  1'b0, 32'h0000_2005, 1'b1, "R12 "}, // tag4, lru, valid
        '{M_TS,   1'b0, 1'b1, 1'b1, 32'h1230, 32'h0,         K_RAM,  1'b0, 32'h0000_1001, 1'b1, "R12 "}, // no lru via way1
        '{M_TS,   1'b1, 1'b1, 1'b0, 32'h1230, 32'h0000_3800, K_RAM,  1'b0, 32'h0,         1'b1, "R12 "}, // tag write
        '{M_TS,   1'b0, 1'b1, 1'b0, 32'h1230, 32'h0,         K_RAM,  1'b0, 32'h0000_3805, 1'b1, "R12 "}, // flags unchanged
        '{M_DIS,  1'b0, 1'b0, 1'b0, 32'h1230, 32'h0,         K_BYP,  1'b0, 32'h0,         1'b1, "R4  "},
        '{M_EN,   1'b1, 1'b0, 1'b0, 32'h1230, 32'h5,         K_BYP,  1'b0, 32'h0,         1'b1, "R4  "},
        '{M_LK,   1'b1, 1'b1, 1'b0, 32'h0050, 32'h0000_4800, K_RAM,  1'b0, 32'h0,         1'b1, "R11 "}, // lock set5 way0 tag9
        '{M_LK,   1'b0, 1'b1, 1'b0, 32'h0050, 32'h0,         K_RAM,  1'b0, 32'h0000_4803, 1'b1, "R11 "},
        '{M_ENLK, 1'b0, 1'b0, 1'b1, 32'h1230, 32'h0,         K_RAM,  1'b0, 32'h2222_0000, 1'b1, "R11 "}, // no caching
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h0050, 32'h0,         K_FILL, 1'b1, 32'h0,         1'b0, "R8  "}, // LRU=0 is locked
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h4850, 32'h0,         K_HIT,  1'b0, 32'h0,         1'b0, "R11 "}, // locked line hits
        '{M_LK,   1'b1, 1'b1, 1'b1, 32'h0050, 32'h0000_5000, K_RAM,  1'b0, 32'h0,         1'b1, "R9  "}, // both locked
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h0050, 32'h0,         K_NSEQ, 1'b0, 32'h0,         1'b1, "R9  "},
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h5050, 32'h0,         K_HIT,  1'b1, 32'h0,         1'b0, "R9  "},
        '{M_ENGL, 1'b0, 1'b0, 1'b0, 32'h2A30, 32'h0,         K_NSEQ, 1'b0, 32'h0,         1'b1, "R10 "},
        '{M_ENGL, 1'b0, 1'b0, 1'b0, 32'h3A30, 32'h0,         K_HIT,  1'b0, 32'h1111_0000, 1'b1, "R10 "},
        '{M_EN,   1'b0, 1'b0, 1'b0, 32'h2A30, 32'h0,         K_FILL, 1'b1, 32'h0,         1'b0, "R10 "}, // replacement resumes
        '{M_TS,   1'b0, 1'b1, 1'b0, 32'h0050, 32'h0,         K_RAM,  1'b0, 32'h0000_4803, 1'b1, "R10 "}  // lock kept
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_global_lock = 1'b0, cfg_lock_mode = 1'b0, cfg_test_mode = 1'b0;
    logic        flush_req = 1'b0;
    logic        flush_busy;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_tag_sel = 1'b0, cpu_way = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_fill, rsp_nseq, rsp_bypass, rsp_ram, rsp_way;
    logic [31:0] rsp_rdata;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ctc_tag_ctrl i_ctc_tag_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_global_lock(cfg_global_lock),
        .cfg_lock_mode(cfg_lock_mode), .cfg_test_mode(cfg_test_mode),
        .flush_req(flush_req), .flush_busy(flush_busy),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag_sel(cpu_tag_sel), .cpu_way(cpu_way),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fill(rsp_fill), .rsp_nseq(rsp_nseq),
        .rsp_bypass(rsp_bypass), .rsp_ram(rsp_ram), .rsp_way(rsp_way), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request at a negedge; return at the next negedge with the response registered.
    task automatic do_req(input logic [3:0] mode, input logic we, input logic tsel,
                          input logic way, input logic [31:0] addr, input logic [31:0] wd);
        {cfg_enable, cfg_global_lock, cfg_lock_mode, cfg_test_mode} = mode;
        cpu_we = we; cpu_tag_sel = tsel; cpu_way = way; cpu_addr = addr; cpu_wdata = wd;
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    function automatic logic [4:0] flags();
        return {rsp_ram, rsp_bypass, rsp_nseq, rsp_fill, rsp_hit};
    endfunction

    // Count sampled cycles with busy high, starting at the current negedge.
    task automatic count_busy(output int n);
        n = 0;
        while (flush_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_flush();
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
    endtask

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!rsp_valid && flush_busy, "R1", "reset state {valid,busy}",
            {30'd0, rsp_valid, flush_busy}, 32'h1);
        rst_n = 1'b1;
        count_busy(n);
        chk(n == 128, "R2", "busy cycles after reset", n, 128);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i].mode, VEC[i].we, VEC[i].tsel, VEC[i].way, VEC[i].addr, VEC[i].wdata);
            chk(rsp_valid && flags() == (5'b1 << VEC[i].kind), string'(VEC[i].req),
                $sformatf("step %0d outcome", i), {27'd0, flags()}, {27'd0, 5'b1 << VEC[i].kind});
            if (VEC[i].kind == K_HIT || VEC[i].kind == K_FILL)
                chk(rsp_way == VEC[i].eway, string'(VEC[i].req),
                    $sformatf("step %0d way", i), {31'd0, rsp_way}, {31'd0, VEC[i].eway});
            if (VEC[i].ck)
                chk(rsp_rdata == VEC[i].erd, string'(VEC[i].req),
                    $sformatf("step %0d rdata", i), rsp_rdata, VEC[i].erd);
        end

        // R2: commanded sweep length and self-clearing busy
        pulse_flush();
        count_busy(n);
        chk(n == 128, "R2", "busy cycles after flush_req", n, 128);
        // R3: flags cleared, tag value kept (set5 way1 held tag 10, locked)
        do_req(M_TS, 1'b0, 1'b1, 1'b1, 32'h0050, 32'h0);
        chk(rsp_rdata == 32'h0000_5000, "R3", "tag word after sweep", rsp_rdata, 32'h0000_5000);
        // R3: previous hit now misses and allocates LRU way 0
        do_req(M_EN, 1'b0, 1'b0, 1'b0, 32'h3A30, 32'h0);
        chk(rsp_fill && rsp_way == 1'b0, "R3", "lookup after sweep {fill,way}",
            {30'd0, rsp_fill, rsp_way}, 32'h2);

        // R3: request during a sweep passes through
        pulse_flush();
        do_req(M_EN, 1'b0, 1'b0, 1'b0, 32'h3A30, 32'h0);
        chk(rsp_bypass, "R3", "request during sweep bypass", {31'd0, rsp_bypass}, 32'h1);
        count_busy(n);

        // R13: second pulse mid-sweep restarts the count
        pulse_flush();
        repeat (40) @(negedge clk);
        pulse_flush();
        count_busy(n);
        chk(n == 128, "R13", "busy cycles after restart", n, 128);

        // R14: no response without a request
        @(negedge clk);
        chk(!rsp_valid && flags() == 5'b0, "R14", "idle response", {27'd0, flags()}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule